// File: doc/BRIEF.md
# Framebuffer Control Registers with Vertical-Sync Interrupt

This block is the small register bank of an 8-bit framebuffer controller. It sits on a 32-byte register window reached through a simple synchronous bus. Each access has a start offset, a byte count from one to four, and a write or read strobe. The bank holds four kinds of register:

- a control byte, whose top bit arms the vertical-sync interrupt;
- a status byte;
- fourteen general read/write bytes, used by software for cursor and video-control settings;
- an undecoded lower half of the window.

Once per frame the display timing delivers a one-cycle vertical-sync pulse. If interrupts are armed, the pulse latches a pending flag, and that flag drives a level interrupt line. The status byte reports this flag together with fixed board-identity bits: a monitor sense code and a colour-board marker. Software acknowledges the interrupt by writing any value to the status byte.

Read data is registered and appears one cycle after the read strobe. It holds its value until the next read. A read and a write in the same cycle return the contents from before the write.

Top module: `fbc_regbank`

## Requirements
- R1: The control byte lives at offset 0x10, is fully readable and writable, and its bit 7 is the interrupt enable.
- R2: A vsync pulse while control bit 7 is 1 sets the pending flag, and irq is high from the next cycle. A vsync pulse while control bit 7 is 0 changes nothing.
- R3: A read of offset 0x11 (status) returns 0x61 (bits 6:5 = 11 monitor code, bit 0 = 1 colour board), with bit 7 equal to the pending flag.
- R4: Any write that covers offset 0x11 clears the pending flag and drops irq on the next cycle, whatever the data byte. When nothing is pending, such a write has no effect.
- R5: When a vsync pulse (with interrupts enabled) and a status write fall in the same cycle, the flag ends up set.
- R6: Offsets 0x12 to 0x1F are independent read/write bytes, and each one changes only when a write covers it.
- R7: Offsets 0x00 to 0x0F read as zero, and writes to them change no register.
- R8: bus_size encodes the access length: 0 means 1 byte, up to 3 meaning 4 bytes. The bytes go to consecutive offsets starting at bus_addr. The lowest offset maps to the most significant used byte, and data is right-justified in the 32-bit word. Offsets past 0x1F are dropped on writes and read as zero.
- R9: Reset (synchronous, active high) clears the control byte, the general bytes, the pending flag and read data, and holds irq low.
- R10: Read data updates exactly one cycle after bus_rd and holds otherwise. A read in the same cycle as a write returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (5) | Start offset inside the register window |
| bus_size | input | SZ_W (2) | Access length minus one |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W (32) | Write data, right-justified |
| vsync | input | 1 | One-cycle vertical-sync pulse |
| rd_data | output | DATA_W (32) | Registered read data |
| irq | output | 1 | Level interrupt, high while the flag is pending |

## Verification
On every cycle, the embedded properties check the following:
- the flag is set after an armed vsync, and rises for no other reason;
- it is cleared by an unopposed acknowledge;
- the set wins a collision with an acknowledge;
- the control byte loads what was written;
- the general bytes and read data hold when not addressed.

They also check the fixed identity bits on status reads and the zero result for undecoded offsets. Only the bench scenarios can show the remaining behaviours:
- the exact byte ordering of multi-byte accesses;
- truncation at the window end;
- the contents returned for reads and writes in the same cycle;
- that acknowledge data is ignored;
- that reset clears every register.

// File: rtl/fbc_pkg.sv
`timescale 1ns/1ps
package fbc_pkg;
  typedef logic [7:0] byte_t;

  // first decoded offset; everything below reads zero
  localparam int DEC_BASE   = 16;
  localparam int CTRL_OFF   = 16;
  localparam int STAT_OFF   = 17;
  localparam int SCR_LO     = 18;

  localparam int IRQ_EN_BIT = 7;
  localparam int PEND_BIT   = 7;

  // monitor sense code (bits 6:5) and colour-board marker (bit 0)
  localparam byte_t STAT_FIXED = 8'h61;
endpackage

// File: rtl/fbc_lane_dec.sv
`timescale 1ns/1ps
module fbc_lane_dec
  import fbc_pkg::*;
#(
  parameter int WIN    = 32,
  parameter int BASE   = 16,
  parameter int ADDR_W = $clog2(WIN),
  parameter int LANES  = 4,
  parameter int SZ_W   = $clog2(LANES),
  localparam int CNT   = WIN - BASE
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [SZ_W-1:0]    size,
  input  logic               wr_en,
  input  logic [8*LANES-1:0] wdata,
  output logic [CNT-1:0]     hit,
  output byte_t              wbyte [CNT]
);
  for (genvar i = 0; i < CNT; i++) begin : g_off
    logic  hit_l;
    byte_t byte_l;
    always_comb begin
      int k;
      k = (BASE + i) - int'(addr);
      hit_l  = 1'b0;
      byte_l = '0;
      if (wr_en && k >= 0 && k <= int'(size)) begin
        hit_l  = 1'b1;
        byte_l = wdata[8*(int'(size) - k) +: 8];
      end
    end
    assign hit[i]   = hit_l;
    assign wbyte[i] = byte_l;
  end
endmodule

// File: rtl/fbc_irq_ctrl.sv
`timescale 1ns/1ps
module fbc_irq_ctrl
  import fbc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  vsync,
  input  logic  ctrl_we,
  input  byte_t ctrl_wbyte,
  input  logic  stat_we,
  output byte_t ctrl_q,
  output logic  pend_q
);
  logic arm;
  assign arm = vsync & ctrl_q[IRQ_EN_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_wbyte;
      if (arm)          pend_q <= 1'b1;
      else if (stat_we) pend_q <= 1'b0;
    end
  end

  // R1
  ctrl_load_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_we |=> ctrl_q == $past(ctrl_wbyte));
  // R2
  arm_set_chk: assert property (@(posedge clk) disable iff (rst)
    (vsync && ctrl_q[IRQ_EN_BIT]) |=> pend_q);
  // R2
  no_stray_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q) |-> $past(vsync && ctrl_q[IRQ_EN_BIT]));
  // R4
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_we && !(vsync && ctrl_q[IRQ_EN_BIT])) |=> !pend_q);
  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_we && vsync && ctrl_q[IRQ_EN_BIT]) |=> pend_q);
endmodule

// File: rtl/fbc_scratch.sv
`timescale 1ns/1ps
module fbc_scratch
  import fbc_pkg::*;
#(
  parameter int CNT = 14
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [CNT-1:0] hit,
  input  byte_t          wbyte [CNT],
  output byte_t          q     [CNT]
);
  for (genvar i = 0; i < CNT; i++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)         q[i] <= '0;
      else if (hit[i]) q[i] <= wbyte[i];
    end

    // R6
    scr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !hit[i] |=> $stable(q[i]));
  end
endmodule

// File: rtl/fbc_regbank.sv
`timescale 1ns/1ps
module fbc_regbank
  import fbc_pkg::*;
#(
  parameter int WIN    = 32,
  parameter int DATA_W = 32,
  localparam int LANES  = DATA_W / 8,
  localparam int ADDR_W = $clog2(WIN),
  localparam int SZ_W   = $clog2(LANES),
  localparam int DCNT   = WIN - DEC_BASE,
  localparam int SCNT   = WIN - SCR_LO
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [SZ_W-1:0]   bus_size,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              vsync,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  logic [DCNT-1:0] hit;
  byte_t           wbyte [DCNT];
  byte_t           ctrl_q;
  logic            pend_q;
  byte_t           scr_q [SCNT];
  byte_t           view  [WIN];
  logic [DATA_W-1:0] rd_next;
  byte_t           unused_stat_data;

  fbc_lane_dec #(
    .WIN(WIN), .BASE(DEC_BASE), .ADDR_W(ADDR_W), .LANES(LANES), .SZ_W(SZ_W)
  ) dec_i (
    .addr(bus_addr), .size(bus_size), .wr_en(bus_wr), .wdata(bus_wdata),
    .hit(hit), .wbyte(wbyte)
  );

  fbc_irq_ctrl irq_i (
    .clk(clk), .rst(rst), .vsync(vsync),
    .ctrl_we(hit[CTRL_OFF-DEC_BASE]), .ctrl_wbyte(wbyte[CTRL_OFF-DEC_BASE]),
    .stat_we(hit[STAT_OFF-DEC_BASE]),
    .ctrl_q(ctrl_q), .pend_q(pend_q)
  );

  // the acknowledge data byte carries no meaning
  assign unused_stat_data = wbyte[STAT_OFF-DEC_BASE];

  fbc_scratch #(.CNT(SCNT)) scr_i (
    .clk(clk), .rst(rst),
    .hit(hit[DCNT-1:SCR_LO-DEC_BASE]),
    .wbyte(wbyte[SCR_LO-DEC_BASE:DCNT-1]),
    .q(scr_q)
  );

  for (genvar o = 0; o < WIN; o++) begin : g_view
    if (o == CTRL_OFF) begin : g_ctrl
      assign view[o] = ctrl_q;
    end else if (o == STAT_OFF) begin : g_stat
      assign view[o] = STAT_FIXED | byte_t'({pend_q, 7'b0});
    end else if (o >= SCR_LO) begin : g_scr
      assign view[o] = scr_q[o-SCR_LO];
    end else begin : g_undef
      assign view[o] = '0;
    end
  end

  always_comb begin
    rd_next = '0;
    for (int k = 0; k < LANES; k++) begin
      int o;
      o = int'(bus_addr) + k;
      if (k <= int'(bus_size) && o < WIN)
        rd_next[8*(int'(bus_size) - k) +: 8] = view[o[ADDR_W-1:0]];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (bus_rd) rd_data <= rd_next;
  end

  assign irq = pend_q;

  // R3
  stat_id_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && int'(bus_addr) == STAT_OFF && bus_size == '0)
      |=> (rd_data[6:5] == 2'b11 && rd_data[0]));
  // R7
  undef_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && int'(bus_addr) < DEC_BASE - LANES) |=> rd_data == '0);
  // R8
  tail_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_size == SZ_W'(LANES-1) && int'(bus_addr) == WIN-1)
      |=> rd_data[DATA_W-9:0] == '0);
  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(rd_data));
endmodule

// File: tb/fbc_regbank_tb_top.sv
`timescale 1ns/1ps
module fbc_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        vsync = 1'b0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0]  mdl [32];
  logic        pend_m;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  bit          rd_seen = 1'b0;

  always #5 clk = ~clk;

  fbc_regbank dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .vsync(vsync), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] mbyte(input int o);
    if (o == 17) return 8'h61 | {pend_m, 7'b0};
    if (o >= 16 && o < 32) return mdl[o];
    return 8'h00;
  endfunction

  function automatic logic [31:0] exp_read(input int a, input int sz);
    logic [31:0] r;
    r = '0;
    for (int k = 0; k <= sz; k++)
      if (a + k < 32) r[8*(sz-k) +: 8] = mbyte(a + k);
    return r;
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic model_write(input int a, input int sz, input logic [31:0] d);
    for (int k = 0; k <= sz; k++) begin
      int o;
      o = a + k;
      if (o == 17) pend_m = 1'b0;
      else if (o >= 16 && o < 32) mdl[o] = d[8*(sz-k) +: 8];
    end
  endtask

  task automatic do_write(input int a, input int sz, input logic [31:0] d);
    bus_addr = 5'(a); bus_size = 2'(sz); bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0;
    model_write(a, sz, d);
  endtask

  task automatic do_read(input int a, input int sz, input string tag);
    exp_q.push_back(exp_read(a, sz));
    tag_q.push_back(tag);
    bus_addr = 5'(a); bus_size = 2'(sz); bus_rd = 1'b1;
    step();
    bus_rd = 1'b0;
  endtask

  task automatic do_vsync(input bit with_ack);
    vsync = 1'b1;
    if (with_ack) begin
      bus_addr = 5'd17; bus_size = 2'd0; bus_wdata = 32'hFF; bus_wr = 1'b1;
    end
    step();
    vsync = 1'b0;
    bus_wr = 1'b0;
    if (with_ack && !mdl[16][7]) pend_m = 1'b0;
    if (mdl[16][7]) pend_m = 1'b1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
    for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
    pend_m = 1'b0;
  endtask

  // monitor: compares registered read data one cycle after each read strobe
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10: unexpected read result %h expected none", rd_data);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rd_data, e, t);
      end
    end
    rd_seen = bus_rd;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R9 reset state
    chk({31'b0, irq}, 32'h0, "R9 irq after reset");
    chk(rd_data, 32'h0, "R9 read data after reset");
    do_read(16, 0, "R9 control cleared");
    do_read(18, 0, "R9 general byte cleared");
    do_read(17, 0, "R3 status idle 0x61");

    // R2 disabled vsync ignored
    do_vsync(1'b0);
    chk({31'b0, irq}, 32'h0, "R2 vsync while disabled");
    do_read(17, 0, "R2 status no pending");

    // R1 enable, R2 set
    do_write(16, 0, 32'h80);
    do_read(16, 0, "R1 control readback");
    do_vsync(1'b0);
    chk({31'b0, irq}, 32'h1, "R2 irq raised");
    do_read(17, 0, "R3 status with pending 0xE1");

    // R4 acknowledge with zero data
    do_write(17, 0, 32'h00);
    chk({31'b0, irq}, 32'h0, "R4 ack with zero data");
    do_read(17, 0, "R4 status after ack");
    // R4 ack with nothing pending: no effect, next vsync still fires
    do_write(17, 0, 32'h80);
    chk({31'b0, irq}, 32'h0, "R4 ack when idle");
    do_vsync(1'b0);
    chk({31'b0, irq}, 32'h1, "R4 vsync after idle ack");

    // R5 collision: set wins
    do_vsync(1'b1);
    chk({31'b0, irq}, 32'h1, "R5 set beats ack");
    do_write(17, 0, 32'h5A);
    chk({31'b0, irq}, 32'h0, "R4 ack after collision");

    // R6 general bytes
    do_write(18, 0, 32'hA5);
    do_write(31, 0, 32'h3C);
    do_read(18, 0, "R6 byte 0x12");
    do_read(31, 0, "R6 byte 0x1F");
    do_read(19, 0, "R6 neighbour untouched");

    // R7 undecoded offsets
    do_write(5, 0, 32'hFF);
    do_write(12, 3, 32'hFFFF_FFFF);
    do_read(5, 0, "R7 undecoded reads zero");
    do_read(16, 3, "R7 decoded bytes unchanged");

    // R8 multi-byte ordering and truncation
    do_write(20, 3, 32'h1122_3344);
    do_read(20, 3, "R8 four-byte readback");
    do_read(21, 1, "R8 two-byte middle read");
    do_read(22, 2, "R8 three-byte read");
    do_write(30, 3, 32'hDEAD_BEEF);
    do_read(30, 3, "R8 read past window end");
    do_read(29, 0, "R8 byte before tail");

    // R10 same-cycle read and write, then hold
    exp_q.push_back(exp_read(24, 0));
    tag_q.push_back("R10 read sees old contents");
    bus_addr = 5'd24; bus_size = 2'd0; bus_wdata = 32'h77;
    bus_wr = 1'b1; bus_rd = 1'b1;
    step();
    bus_wr = 1'b0; bus_rd = 1'b0;
    model_write(24, 0, 32'h77);
    step(); step(); step();
    chk(rd_data, 32'h0, "R10 read data holds");
    do_read(24, 0, "R10 write landed");

    // R2 disable again
    do_write(16, 0, 32'h00);
    do_vsync(1'b0);
    chk({31'b0, irq}, 32'h0, "R2 disabled again");

    // R9 reset mid-run with pending
    do_write(16, 0, 32'h80);
    do_vsync(1'b0);
    chk({31'b0, irq}, 32'h1, "R2 pending before reset");
    do_reset();
    chk({31'b0, irq}, 32'h0, "R9 irq dropped by reset");
    chk(rd_data, 32'h0, "R9 read data zero after reset");
    do_read(16, 3, "R9 registers cleared");
    do_read(28, 3, "R9 tail cleared");

    step(); step();
    chk(32'(exp_q.size()), 32'h0, "R10 all reads returned");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule